// File: doc/BRIEF.md
# Shift-Based Automatic Gain Control

This block scales a stream of signed receive samples by a power of two and retunes that scale once per frame. The gain is a signed shift amount between -7 and +7: a positive gain moves the sample left, a negative gain moves it right with sign extension. When a left shift would not fit in the sample width, the result clips to the nearest end of the signed range.

While a frame runs, the block tracks the largest output magnitude and counts the samples that clipped. A one-cycle frame strobe latches both figures for status and clears them. In the same clock edge, the gain controller compares the frame result with a programmable target. On clipping or overshoot it lowers the gain by the attack step and starts a holdoff of a programmable number of frames. When the peak is below the target and no holdoff is pending, it raises the gain by the decay step.

With automatic control switched off, the gain follows a manually supplied value. A saturation flag, valid for the whole following frame, tells an outer control loop that the last frame clipped.

Top module: `agc_shift_top`

## Requirements
- R1: Each sample accepted with `in_valid` high appears on `out_sample`, with `out_valid` high, exactly one clock later. It is scaled by the gain held in that cycle: gain g >= 0 multiplies by 2^g, and gain g < 0 is an arithmetic right shift by -g (rounding toward minus infinity). Without `in_valid`, `out_valid` is low the next cycle.
- R2: When a left shift exceeds the signed DATA_W range, the output is 2^(DATA_W-1)-1 for a positive overflow and -2^(DATA_W-1) for a negative one, and the sample counts as one saturation event.
- R3: On a `frame_tick` cycle, `last_peak` takes the largest output magnitude of the frame just closed, and `last_sat_count` takes its saturation event count. The count stops at 2^SATC_W-1. A sample presented in the tick cycle belongs to the new frame.
- R4: With automatic control on, a frame that had any saturation event, or a peak above `target_peak`, lowers the gain at the tick by `attack_step`, not below -7. It also loads the holdoff counter with `holdoff_frames`.
- R5: With automatic control on, a frame whose peak is below `target_peak` and that had no saturation raises the gain by `decay_step`, not above +7, if the holdoff counter is zero. Otherwise the gain is unchanged and the counter drops by one. The gain never changes between ticks.
- R6: A frame whose peak equals `target_peak` without saturation leaves the gain unchanged.
- R7: While `agc_en` is low, `cur_gain` takes `manual_gain` one cycle later (a manual value of -8 is taken as -7), and frame ticks do not alter it. The holdoff counter is held at zero. On enabling, automatic control starts from the current gain.
- R8: `sat_flag` is high exactly when the last closed frame had at least one saturation event, and `agc_active` reports `agc_en` delayed by one cycle.
- R9: After reset, `cur_gain`, `last_peak`, `last_sat_count`, `sat_flag`, `agc_active` and `out_valid` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample strobe |
| in_sample | input | DATA_W | Signed input sample |
| frame_tick | input | 1 | One-cycle strobe closing the current frame |
| agc_en | input | 1 | Automatic gain control enable |
| target_peak | input | DATA_W | Unsigned peak magnitude target |
| attack_step | input | 3 | Gain decrement on overshoot or clipping |
| decay_step | input | 3 | Gain increment on undershoot |
| holdoff_frames | input | HOLD_W | Frames to wait after an attack before increasing |
| manual_gain | input | 4 | Signed gain used while automatic control is off |
| out_valid | output | 1 | Output sample strobe |
| out_sample | output | DATA_W | Signed scaled sample |
| cur_gain | output | 4 | Signed current gain |
| last_peak | output | DATA_W | Peak output magnitude of the last closed frame |
| last_sat_count | output | SATC_W | Saturation events in the last closed frame |
| agc_active | output | 1 | Registered copy of the enable |
| sat_flag | output | 1 | Last closed frame had a saturation event |

## Verification
The bench builds the block with DATA_W of 8, SATC_W of 3 and HOLD_W of 4. Eight-bit samples let modest inputs overflow at small gains, and push the most negative value through a seven-place right shift. The three-bit counter lets nine clipping samples in one frame show the count pinned at seven. The short holdoff width keeps the multi-frame attack, wait and decay sequence, and both gain clamps, within a few dozen frames.

// File: rtl/agc_pkg.sv
package agc_pkg;

    localparam int GAIN_W   = 4;
    localparam int GAIN_MAX = 7;
    localparam int STEP_W   = 3;
    localparam int SUM_W    = 6;

    typedef logic signed [GAIN_W-1:0] gain_t;
    typedef logic [STEP_W-1:0]        step_t;

    typedef enum logic [1:0] {
        ACT_KEEP   = 2'd0,
        ACT_ATTACK = 2'd1,
        ACT_DECAY  = 2'd2,
        ACT_WAIT   = 2'd3
    } agc_act_e;

    function automatic gain_t clamp_gain(input logic signed [SUM_W-1:0] v);
        if (v > SUM_W'(GAIN_MAX))
            return gain_t'(GAIN_MAX);
        else if (v < -SUM_W'(GAIN_MAX))
            return gain_t'(-GAIN_MAX);
        else
            return v[GAIN_W-1:0];
    endfunction

    function automatic gain_t step_gain(input gain_t g, input step_t s, input logic up);
        logic signed [SUM_W-1:0] gx;
        logic signed [SUM_W-1:0] sx;
        gx = SUM_W'(g);
        sx = $signed({{(SUM_W-STEP_W){1'b0}}, s});
        return up ? clamp_gain(gx + sx) : clamp_gain(gx - sx);
    endfunction

endpackage

// File: rtl/agc_shift_stage.sv
module agc_shift_stage
    import agc_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  gain_t                     gain,
    input  logic signed [DATA_W-1:0]  x,
    output logic signed [DATA_W-1:0]  y,
    output logic                      sat,
    output logic        [DATA_W-1:0]  mag
);
    localparam int EXT_W = DATA_W + GAIN_MAX;
    localparam logic signed [DATA_W-1:0] POS_LIM = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic signed [DATA_W-1:0] NEG_LIM = {1'b1, {(DATA_W-1){1'b0}}};

    logic signed [EXT_W-1:0]  ext;
    logic signed [EXT_W-1:0]  shl;
    logic signed [DATA_W-1:0] shr;
    gain_t                    neg_gain;
    logic [2:0]               amt_l;
    logic [2:0]               amt_r;
    logic                     ovf;
    logic [EXT_W-DATA_W:0]    top_bits;

    always_comb begin
        neg_gain = -gain;
        amt_l    = gain[GAIN_W-1] ? 3'd0 : gain[2:0];
        amt_r    = gain[GAIN_W-1] ? neg_gain[2:0] : 3'd0;
        ext      = {{GAIN_MAX{x[DATA_W-1]}}, x};
        shl      = ext <<< amt_l;
        shr      = x >>> amt_r;
        top_bits = shl[EXT_W-1:DATA_W-1];
        ovf      = !((&top_bits) || (~|top_bits));
        if (gain[GAIN_W-1]) begin
            y   = shr;
            sat = 1'b0;
        end else if (ovf) begin
            y   = shl[EXT_W-1] ? NEG_LIM : POS_LIM;
            sat = 1'b1;
        end else begin
            y   = shl[DATA_W-1:0];
            sat = 1'b0;
        end
        mag = y[DATA_W-1] ? DATA_W'(-y) : DATA_W'(y);
    end

    // R2: a clipped result sits at one of the two range ends
    always_comb begin
        if (sat) begin
            assert_clip_at_limit_R2: assert (y == POS_LIM || y == NEG_LIM);
        end
    end

endmodule

// File: rtl/agc_frame_stats.sv
module agc_frame_stats #(
    parameter int DATA_W = 16,
    parameter int SATC_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              valid,
    input  logic [DATA_W-1:0] mag,
    input  logic              sat,
    input  logic              tick,
    output logic [DATA_W-1:0] acc_peak,
    output logic [SATC_W-1:0] acc_sat,
    output logic [DATA_W-1:0] last_peak,
    output logic [SATC_W-1:0] last_sat
);
    localparam logic [SATC_W-1:0] SAT_CAP = {SATC_W{1'b1}};

    logic sat_hit;
    assign sat_hit = valid && sat;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_peak  <= '0;
            acc_sat   <= '0;
            last_peak <= '0;
            last_sat  <= '0;
        end else if (tick) begin
            last_peak <= acc_peak;
            last_sat  <= acc_sat;
            acc_peak  <= valid ? mag : '0;
            acc_sat   <= sat_hit ? SATC_W'(1) : '0;
        end else begin
            if (valid && mag > acc_peak)
                acc_peak <= mag;
            if (sat_hit && acc_sat != SAT_CAP)
                acc_sat <= acc_sat + SATC_W'(1);
        end
    end

    // R3: a fresh frame holds at most the tick-cycle sample
    assert_frame_restart_R3: assert property (@(posedge clk) disable iff (rst)
        tick |=> acc_sat <= SATC_W'(1));

    // R3: within a frame the counts never fall
    assert_monotone_R3: assert property (@(posedge clk) disable iff (rst)
        !tick |=> (acc_sat >= $past(acc_sat) && acc_peak >= $past(acc_peak)));

endmodule

// File: rtl/agc_gain_ctrl.sv
module agc_gain_ctrl
    import agc_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int SATC_W = 16,
    parameter int HOLD_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              tick,
    input  logic [DATA_W-1:0] acc_peak,
    input  logic [SATC_W-1:0] acc_sat,
    input  logic [DATA_W-1:0] target,
    input  step_t             attack,
    input  step_t             decay,
    input  logic [HOLD_W-1:0] holdoff,
    input  gain_t             manual,
    output gain_t             gain
);
    logic [HOLD_W-1:0] hold_cnt;
    agc_act_e          act;

    always_comb begin
        if (acc_sat != '0 || acc_peak > target)
            act = ACT_ATTACK;
        else if (acc_peak < target)
            act = (hold_cnt == '0) ? ACT_DECAY : ACT_WAIT;
        else
            act = ACT_KEEP;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gain     <= '0;
            hold_cnt <= '0;
        end else if (!en) begin
            gain     <= (manual == gain_t'(-8)) ? gain_t'(-GAIN_MAX) : manual;
            hold_cnt <= '0;
        end else if (tick) begin
            unique case (act)
                ACT_ATTACK: begin
                    gain     <= step_gain(gain, attack, 1'b0);
                    hold_cnt <= holdoff;
                end
                ACT_DECAY:  gain     <= step_gain(gain, decay, 1'b1);
                ACT_WAIT:   hold_cnt <= hold_cnt - HOLD_W'(1);
                default:    ;
            endcase
        end
    end

    // R4/R5: gain always inside the shift range
    assert_gain_range_R4: assert property (@(posedge clk) disable iff (rst)
        gain >= gain_t'(-GAIN_MAX) && gain <= gain_t'(GAIN_MAX));

    // R5: under automatic control the gain moves only at frame ticks
    assert_hold_between_frames_R5: assert property (@(posedge clk) disable iff (rst)
        (en && !tick) |=> $stable(gain));

    // R4: an attack never raises the gain
    assert_attack_down_R4: assert property (@(posedge clk) disable iff (rst)
        (en && tick && act == ACT_ATTACK) |=> gain <= $past(gain));

    // R7: disabled control tracks the manual value
    assert_manual_track_R7: assert property (@(posedge clk) disable iff (rst)
        !en |=> (gain == $past(manual) || ($past(manual) == gain_t'(-8) && gain == gain_t'(-GAIN_MAX))));

endmodule

// File: rtl/agc_shift_top.sv
module agc_shift_top
    import agc_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int SATC_W = 16,
    parameter int HOLD_W = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] in_sample,
    input  logic                     frame_tick,
    input  logic                     agc_en,
    input  logic        [DATA_W-1:0] target_peak,
    input  logic        [2:0]        attack_step,
    input  logic        [2:0]        decay_step,
    input  logic        [HOLD_W-1:0] holdoff_frames,
    input  logic signed [3:0]        manual_gain,
    output logic                     out_valid,
    output logic signed [DATA_W-1:0] out_sample,
    output logic signed [3:0]        cur_gain,
    output logic        [DATA_W-1:0] last_peak,
    output logic        [SATC_W-1:0] last_sat_count,
    output logic                     agc_active,
    output logic                     sat_flag
);
    gain_t                    gain;
    logic signed [DATA_W-1:0] scaled;
    logic                     clip;
    logic        [DATA_W-1:0] mag;
    logic        [DATA_W-1:0] acc_peak;
    logic        [SATC_W-1:0] acc_sat;

    agc_shift_stage #(.DATA_W(DATA_W)) u_shift (
        .gain (gain),
        .x    (in_sample),
        .y    (scaled),
        .sat  (clip),
        .mag  (mag)
    );

    agc_frame_stats #(.DATA_W(DATA_W), .SATC_W(SATC_W)) u_stats (
        .clk       (clk),
        .rst       (rst),
        .valid     (in_valid),
        .mag       (mag),
        .sat       (clip),
        .tick      (frame_tick),
        .acc_peak  (acc_peak),
        .acc_sat   (acc_sat),
        .last_peak (last_peak),
        .last_sat  (last_sat_count)
    );

    agc_gain_ctrl #(.DATA_W(DATA_W), .SATC_W(SATC_W), .HOLD_W(HOLD_W)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .en       (agc_en),
        .tick     (frame_tick),
        .acc_peak (acc_peak),
        .acc_sat  (acc_sat),
        .target   (target_peak),
        .attack   (attack_step),
        .decay    (decay_step),
        .holdoff  (holdoff_frames),
        .manual   (manual_gain),
        .gain     (gain)
    );

    assign cur_gain = gain;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_sample <= '0;
            agc_active <= 1'b0;
            sat_flag   <= 1'b0;
        end else begin
            out_valid  <= in_valid;
            agc_active <= agc_en;
            if (in_valid)
                out_sample <= scaled;
            if (frame_tick)
                sat_flag <= (acc_sat != '0);
        end
    end

    // R1: one-cycle latency of the sample strobe
    assert_latency_R1: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    assert_no_spurious_R1: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R8: flag agrees with the latched count
    assert_flag_matches_R8: assert property (@(posedge clk) disable iff (rst)
        sat_flag == (last_sat_count != '0));

    // R8: enable mirror
    assert_enable_mirror_R8: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> agc_active == $past(agc_en));

endmodule

// File: tb/agc_shift_top_bench.sv
module agc_shift_top_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DW  = 8;
    localparam int SCW = 3;
    localparam int HW  = 4;

    logic clk = 1'b0;
    logic rst;
    logic in_valid;
    logic signed [DW-1:0] in_sample;
    logic frame_tick;
    logic agc_en;
    logic [DW-1:0] target_peak;
    logic [2:0] attack_step;
    logic [2:0] decay_step;
    logic [HW-1:0] holdoff_frames;
    logic signed [3:0] manual_gain;
    logic out_valid;
    logic signed [DW-1:0] out_sample;
    logic signed [3:0] cur_gain;
    logic [DW-1:0] last_peak;
    logic [SCW-1:0] last_sat_count;
    logic agc_active;
    logic sat_flag;

    int n_checks = 0;
    int n_fail   = 0;
    int exp_gain = 0;
    int exp_q[$];
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    agc_shift_top #(.DATA_W(DW), .SATC_W(SCW), .HOLD_W(HW)) u_agc_shift_top (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
        .frame_tick(frame_tick), .agc_en(agc_en), .target_peak(target_peak),
        .attack_step(attack_step), .decay_step(decay_step),
        .holdoff_frames(holdoff_frames), .manual_gain(manual_gain),
        .out_valid(out_valid), .out_sample(out_sample), .cur_gain(cur_gain),
        .last_peak(last_peak), .last_sat_count(last_sat_count),
        .agc_active(agc_active), .sat_flag(sat_flag)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int model(input int x, input int g);
        int v;
        if (g >= 0) begin
            v = x * (1 << g);
            if (v > 127) v = 127;
            if (v < -128) v = -128;
        end else begin
            v = x >>> (-g);
        end
        return v;
    endfunction

    // driver: one sample, expected result pushed into the scoreboard
    task automatic send(input int x);
        @(negedge clk);
        in_valid  = 1'b1;
        in_sample = DW'(x);
        exp_q.push_back(model(x, exp_gain));
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic tick();
        frame_tick = 1'b1;
        @(negedge clk);
        frame_tick = 1'b0;
    endtask

    task automatic frame_check(input string req, input int peak, input int satc, input int flag, input int g);
        check({req, " peak"}, int'(last_peak), peak);
        check({req, " satcount"}, int'(last_sat_count), satc);
        check({req, " flag"}, int'(sat_flag), flag);
        check({req, " gain"}, int'(cur_gain), g);
        exp_gain = g;
    endtask

    task automatic set_manual(input int g);
        manual_gain = 4'(g);
        @(negedge clk);
        @(negedge clk);
    endtask

    // monitor: pop and compare each produced sample (R1, R2)
    initial begin
        forever begin
            @(negedge clk);
            if (out_valid) begin
                if (exp_q.size() == 0) begin
                    check("R1 unexpected output", 1, 0);
                end else begin
                    check("R1/R2 sample", int'(out_sample), exp_q.pop_front());
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; in_valid = 0; in_sample = '0; frame_tick = 0; agc_en = 0;
        target_peak = 8'd64; attack_step = 3'd2; decay_step = 3'd1;
        holdoff_frames = 4'd2; manual_gain = 4'sd0;
        repeat (3) @(negedge clk);
        // R9 reset state
        check("R9 gain", int'(cur_gain), 0);
        check("R9 peak", int'(last_peak), 0);
        check("R9 satcount", int'(last_sat_count), 0);
        check("R9 flag", int'(sat_flag), 0);
        check("R9 active", int'(agc_active), 0);
        check("R9 out_valid", int'(out_valid), 0);
        rst = 1'b0;
        @(negedge clk);

        // R7 manual gain, R1/R2 left shift with clipping
        set_manual(2);
        check("R7 manual gain", int'(cur_gain), 2);
        exp_gain = 2;
        send(10); send(-20); send(40); send(-50);
        tick();
        frame_check("R3 R8 manual frame", 128, 2, 1, 2);

        // R1 arithmetic right shift
        set_manual(-3);
        exp_gain = -3;
        check("R7 manual -3", int'(cur_gain), -3);
        send(-100); send(100);
        tick();
        frame_check("R3 right shift frame", 13, 0, 0, -3);

        // R7 -8 taken as -7
        set_manual(-8);
        check("R7 manual clamp", int'(cur_gain), -7);
        exp_gain = -7;
        send(-128);
        tick();
        frame_check("R3 deep shift", 1, 0, 0, -7);

        // R3 counter ceiling
        set_manual(7);
        exp_gain = 7;
        for (int i = 0; i < 9; i++) send(1);
        tick();
        frame_check("R3 count ceiling", 127, 7, 1, 7);

        // automatic control
        set_manual(0);
        exp_gain = 0;
        agc_en = 1'b1;
        @(negedge clk);
        check("R8 active", int'(agc_active), 1);
        send(20); tick(); frame_check("R5 decay 1", 20, 0, 0, 1);
        send(20); tick(); frame_check("R5 decay 2", 40, 0, 0, 2);
        send(40); tick(); frame_check("R4 attack", 127, 1, 1, 0);
        send(20); tick(); frame_check("R5 holdoff wait 1", 20, 0, 0, 0);
        send(20); tick(); frame_check("R5 holdoff wait 2", 20, 0, 0, 0);
        send(20); tick(); frame_check("R5 decay after holdoff", 20, 0, 0, 1);
        send(32); tick(); frame_check("R6 equal target", 64, 0, 0, 1);
        attack_step = 3'd7;
        send(100); tick(); frame_check("R4 big attack", 127, 1, 1, -6);
        target_peak = 8'd0; holdoff_frames = 4'd0;
        send(127); tick(); frame_check("R4 clamp low", 1, 0, 0, -7);
        target_peak = 8'd127; decay_step = 3'd7;
        tick(); frame_check("R5 decay 7", 0, 0, 0, 0);
        tick(); frame_check("R5 decay to max", 0, 0, 0, 7);
        tick(); frame_check("R5 clamp high", 0, 0, 0, 7);

        // R7 disabled: ticks leave the manual gain
        agc_en = 1'b0;
        set_manual(3);
        exp_gain = 3;
        check("R8 inactive", int'(agc_active), 0);
        send(5); tick();
        frame_check("R7 tick ignored", 40, 0, 0, 3);

        repeat (3) @(negedge clk);
        check("R1 scoreboard drained", exp_q.size(), 0);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule